// File: doc/BRIEF.md
# Bus-Master DMA Channel Status and Pointer Register

This block holds the software-visible state of one storage bus-master DMA channel. A host register port reaches two aligned 32-bit words inside the channel's window. Offset 0 carries the command byte and the status byte. Offset 4 carries the descriptor table pointer. The DMA engine connects through three plain strobes: a bus abort indication, an end-of-table completion pulse, and the raw interrupt line from the attached storage device.

The status byte has three flags. The interrupt flag is armed by a rising edge of the device interrupt line, seen after a two-flop synchronizer. Software clears it by writing a one, and it stays clear while the line remains high. The error flag latches every bus abort and is cleared in the same write-one-to-clear way. If a set event and a clear arrive in the same cycle, the set wins. The active flag is read-only and follows a channel state machine. The states are `CH_IDLE` and `CH_BUSY`. The transitions are:
- LAUNCH: `CH_IDLE` to `CH_BUSY` on a command write with start set.
- RELAUNCH: `CH_BUSY` stays in `CH_BUSY` on a command write with start set.
- HALT: `CH_BUSY` to `CH_IDLE` on a command write with start clear.
- FINISH: `CH_BUSY` to `CH_IDLE` on an end-of-table pulse when there is no command write in that cycle.

The synchronized interrupt line is tracked by a second machine. Its states are `LINE_LOW` and `LINE_HIGH`. The ARM transition goes from `LINE_LOW` to `LINE_HIGH` and emits the rise pulse. The DISARM transition goes from `LINE_HIGH` to `LINE_LOW`. The descriptor pointer keeps address bits 31:2 and always reads bits 1:0 as zero, so every pointer is DWord aligned.

Top module: `dmastat_regs`

## Requirements
- R1: After reset, offset 0 reads 0. This means start (bit 0), active (bit 16), error (bit 17) and interrupt (bit 18) are all 0. The pointer's reset value is unspecified.
- R2: A rise of `dev_irq`, driven between clock edges, sets the interrupt flag (offset 0, bit 18). The flag is still 0 after the first and second following rising clock edges and reads 1 after the third. Interrupt masking elsewhere plays no part.
- R3: If the interrupt flag is cleared while `dev_irq` stays high, it stays 0. It sets again only after the line falls and rises once more.
- R4: A write with byte enable 2 and a 1 in bit 18 or bit 17 clears the interrupt or error flag. Writing 0 to those bits, or writing with byte enable 2 low, leaves the flags unchanged.
- R5: If a set event for a flag and a write-one-to-clear of that flag occur in the same cycle, the flag reads 1 afterwards.
- R6: A `bus_abort` high at a rising edge sets the error flag (bit 17) from the next cycle on.
- R7: A write to offset 0 with byte enable 0 and bit 0 = 1 sets the start bit (bit 0) and the active flag (bit 16). This applies in both states.
- R8: A write to offset 0 with byte enable 0 and bit 0 = 0 clears start and active. An `eot_done` pulse clears active but not start. If a start = 1 write coincides with `eot_done`, active stays 1. An `eot_done` pulse while idle has no effect.
- R9: The active flag is read-only. Writes to bit 16, and to all unimplemented bits of offset 0, have no effect, and unimplemented bits read 0.
- R10: Offset 4 is the descriptor pointer. Bits 31:2 are written per byte lane under `host_be`. Bits 1:0 always read 0.
- R11: Any offset other than exactly 0 or 4 reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 4 | Byte offset in the channel window |
| host_be | input | 4 | Byte lane enables for the write |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| dev_irq | input | 1 | Raw device interrupt line, asynchronous |
| bus_abort | input | 1 | Target or master abort seen during a bus data transfer |
| eot_done | input | 1 | Last transfer of an end-of-table region completed |

## Verification
Each internal state shows at the ports at once, because offset 0 reflects both state machines and both flags combinationally. A wrong channel state therefore appears as a wrong bit 16 in the cycle after the command write or end-of-table pulse that caused it. A wrong line-tracker state shows as a missing or extra interrupt flag exactly three edges after a line change. A lost set-versus-clear race shows as a 0 where a 1 was due, in the very next read.

// File: rtl/dmastat_pkg.sv
package dmastat_pkg;

    // Register window offsets (byte addresses of aligned words)
    localparam int CTRL_OFS       = 0;
    localparam int PTR_OFS        = 4;

    // Field positions inside the control word
    localparam int CMD_LANE       = 0;
    localparam int STS_LANE       = 2;
    localparam int CMD_START_BIT  = 0;
    localparam int STS_ACT_BIT    = 16;
    localparam int STS_ERR_BIT    = 17;
    localparam int STS_IRQ_BIT    = 18;

    // Pointer alignment
    localparam int PTR_ALIGN_BITS = 2;

    // Sticky flag indices
    localparam int FLAG_ERR       = 0;
    localparam int FLAG_IRQ       = 1;
    localparam int NUM_FLAGS      = 2;

    typedef enum logic {
        CH_IDLE,
        CH_BUSY
    } chan_state_t;

    typedef enum logic {
        LINE_LOW,
        LINE_HIGH
    } line_state_t;

endpackage

// File: rtl/dmastat_irq_detect.sv
module dmastat_irq_detect
    import dmastat_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_line,
    output logic irq_rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   line_s;
    line_state_t            state_q;
    line_state_t            state_d;

    // Synchronizer chain for the asynchronous device line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], irq_line};
        end
    end

    assign line_s = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and outputs: ARM (low->high, emits rise), DISARM (high->low)
    always_comb begin
        state_d  = state_q;
        irq_rise = 1'b0;
        unique case (state_q)
            LINE_LOW: begin
                if (line_s) begin
                    state_d  = LINE_HIGH;
                    irq_rise = 1'b1;
                end
            end
            LINE_HIGH: begin
                if (!line_s) begin
                    state_d = LINE_LOW;
                end
            end
            default: state_d = LINE_LOW;
        endcase
    end

    // A held-high line yields one rise only
    assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rise |=> !irq_rise);

    // A rise needs the synchronized line to have been low one edge earlier
    assert_rise_from_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rise |-> !$past(line_s));

endmodule

// File: rtl/dmastat_chan_fsm.sv
module dmastat_chan_fsm
    import dmastat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic start_wval,
    input  logic eot_done,
    output logic start_bit,
    output logic active
);

    chan_state_t state_q;
    chan_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: LAUNCH, RELAUNCH, HALT, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (cmd_wr && start_wval) begin
                    state_d = CH_BUSY;
                end
            end
            CH_BUSY: begin
                if (cmd_wr) begin
                    state_d = start_wval ? CH_BUSY : CH_IDLE;
                end else if (eot_done) begin
                    state_d = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        active = (state_q == CH_BUSY);
    end

    // Start bit of the command byte, written by software only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_bit <= 1'b0;
        end else if (cmd_wr) begin
            start_bit <= start_wval;
        end
    end

    assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && start_wval) |=> active);

    assert_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !start_wval) |=> !active);

    assert_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && eot_done && !cmd_wr) |=> !active);

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && !eot_done) |=> $stable(active));

endmodule

// File: rtl/dmastat_flags.sv
module dmastat_flags
    import dmastat_pkg::*;
#(
    parameter int NFLAGS = NUM_FLAGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NFLAGS-1:0] set_ev,
    input  logic              sts_wr,
    input  logic [NFLAGS-1:0] clr_req,
    output logic [NFLAGS-1:0] flag_q
);

    for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
        // Sticky write-one-to-clear flag; a set in the same cycle wins
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_ev[i]) begin
                flag_q[i] <= 1'b1;
            end else if (sts_wr && clr_req[i]) begin
                flag_q[i] <= 1'b0;
            end
        end

        assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> flag_q[i]);

        assert_w1c_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_q[i]) |-> $past(sts_wr && clr_req[i]));
    end

endmodule

// File: rtl/dmastat_ptr_reg.sv
module dmastat_ptr_reg
    import dmastat_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ALIGN  = PTR_ALIGN_BITS
) (
    input  logic                    clk,
    input  logic                    wr,
    input  logic [DATA_W/8-1:0]     be,
    input  logic [DATA_W-1:ALIGN]   wdata,
    output logic [DATA_W-1:0]       rd
);

    logic [DATA_W-1:ALIGN] addr_q;

    // Per-bit storage, written under the enable of its byte lane; no reset
    for (genvar b = ALIGN; b < DATA_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (wr && be[b/8]) begin
                addr_q[b] <= wdata[b];
            end
        end
    end

    assign rd = {addr_q, {ALIGN{1'b0}}};

endmodule

// File: rtl/dmastat_regs.sv
module dmastat_regs
    import dmastat_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [DATA_W/8-1:0] host_be,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic                dev_irq,
    input  logic                bus_abort,
    input  logic                eot_done
);

    localparam int LANES = DATA_W / 8;

    logic                 sel_ctrl;
    logic                 sel_ptr;
    logic                 cmd_wr;
    logic                 sts_wr;
    logic                 ptr_wr;
    logic                 irq_rise;
    logic                 start_bit;
    logic                 active;
    logic [NUM_FLAGS-1:0] set_ev;
    logic [NUM_FLAGS-1:0] clr_req;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [DATA_W-1:0]    ptr_rd;
    logic                 unused_wdata;

    // Exact-offset decode; anything else is unmapped
    assign sel_ctrl = (host_addr == ADDR_W'(CTRL_OFS));
    assign sel_ptr  = (host_addr == ADDR_W'(PTR_OFS));
    assign cmd_wr   = host_wr && sel_ctrl && host_be[CMD_LANE];
    assign sts_wr   = host_wr && sel_ctrl && host_be[STS_LANE];
    assign ptr_wr   = host_wr && sel_ptr;

    assign unused_wdata = host_wdata[1];

    dmastat_irq_detect #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_line (dev_irq),
        .irq_rise (irq_rise)
    );

    dmastat_chan_fsm u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (cmd_wr),
        .start_wval (host_wdata[CMD_START_BIT]),
        .eot_done   (eot_done),
        .start_bit  (start_bit),
        .active     (active)
    );

    always_comb begin
        set_ev            = '0;
        clr_req           = '0;
        set_ev[FLAG_ERR]  = bus_abort;
        set_ev[FLAG_IRQ]  = irq_rise;
        clr_req[FLAG_ERR] = host_wdata[STS_ERR_BIT];
        clr_req[FLAG_IRQ] = host_wdata[STS_IRQ_BIT];
    end

    dmastat_flags #(
        .NFLAGS (NUM_FLAGS)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (set_ev),
        .sts_wr  (sts_wr),
        .clr_req (clr_req),
        .flag_q  (flag_q)
    );

    dmastat_ptr_reg #(
        .DATA_W (DATA_W),
        .ALIGN  (PTR_ALIGN_BITS)
    ) u_ptr (
        .clk   (clk),
        .wr    (ptr_wr),
        .be    (host_be[LANES-1:0]),
        .wdata (host_wdata[DATA_W-1:PTR_ALIGN_BITS]),
        .rd    (ptr_rd)
    );

    // Read mux
    always_comb begin
        host_rdata = '0;
        if (sel_ctrl) begin
            host_rdata[CMD_START_BIT] = start_bit;
            host_rdata[STS_ACT_BIT]   = active;
            host_rdata[STS_ERR_BIT]   = flag_q[FLAG_ERR];
            host_rdata[STS_IRQ_BIT]   = flag_q[FLAG_IRQ];
        end else if (sel_ptr) begin
            host_rdata = ptr_rd;
        end
    end

    assert_ptr_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ptr |-> (host_rdata[PTR_ALIGN_BITS-1:0] == '0));

endmodule

// File: tb/dmastat_regs_test.sv
`timescale 1ns/1ps
module dmastat_regs_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [3:0]  host_addr = 4'd0;
    logic [3:0]  host_be = 4'd0;
    logic [31:0] host_wdata = 32'd0;
    logic [31:0] host_rdata;
    logic        dev_irq = 1'b0;
    logic        bus_abort = 1'b0;
    logic        eot_done = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;   // 250 MHz

    dmastat_regs uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_be    (host_be),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .dev_irq    (dev_irq),
        .bus_abort  (bus_abort),
        .eot_done   (eot_done)
    );

    // Reference model built from the requirements
    logic        m_start, m_act, m_err, m_irq;
    logic [31:0] m_ptr;
    logic        m_ptr_known;
    logic        q0, q1, q2;   // line samples: one, two, three edges back

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_start <= 0; m_act <= 0; m_err <= 0; m_irq <= 0;
            m_ptr_known <= 0;
            q0 <= 0; q1 <= 0; q2 <= 0;
        end else begin
            automatic logic cmd_w = host_wr && host_addr == 4'd0 && host_be[0];
            automatic logic sts_w = host_wr && host_addr == 4'd0 && host_be[2];
            automatic logic rise  = q1 && !q2;
            m_irq <= rise | (m_irq & ~(sts_w & host_wdata[18]));
            m_err <= bus_abort | (m_err & ~(sts_w & host_wdata[17]));
            if (cmd_w) begin
                m_start <= host_wdata[0];
                m_act   <= host_wdata[0];
            end else if (eot_done) begin
                m_act <= 1'b0;
            end
            if (host_wr && host_addr == 4'd4) begin
                for (int l = 0; l < 4; l++)
                    if (host_be[l]) m_ptr[l*8 +: 8] <= host_wdata[l*8 +: 8];
                if (host_be == 4'hF) m_ptr_known <= 1'b1;
            end
            q0 <= dev_irq; q1 <= q0; q2 <= q1;
        end
    end

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        if (a == 4'd0) return {13'd0, m_irq, m_err, m_act, 15'd0, m_start};
        if (a == 4'd4) return {m_ptr[31:2], 2'b00};
        return 32'd0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
        host_wr = 1; host_addr = a; host_be = be; host_wdata = d;
        tick();
        host_wr = 0; host_be = 0;
    endtask

    function automatic logic [31:0] rd(input logic [3:0] a);
        host_addr = a;
        return 32'd0;
    endfunction

    task automatic read(input logic [3:0] a, output logic [31:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd1867));
        repeat (3) @(negedge clk);
        read(4'd0, v); check("R1 reset in reset", v, 32'd0);
        rst_n = 1;
        tick();
        read(4'd0, v); check("R1 reset after release", v, 32'd0);

        // R10 pointer
        wr(4'd4, 4'hF, 32'hDEAD_BEEF);
        read(4'd4, v); check("R10 full write", v, 32'hDEAD_BEEC);
        wr(4'd4, 4'b0010, 32'h0000_55FF);
        read(4'd4, v); check("R10 lane write", v, 32'hDEAD_55EC);

        // R2 latency
        dev_irq = 1;
        tick(); read(4'd0, v); check("R2 edge1", v[18], 1'b0);
        tick(); read(4'd0, v); check("R2 edge2", v[18], 1'b0);
        tick(); read(4'd0, v); check("R2 edge3", v[18], 1'b1);

        // R4 no-effect writes
        wr(4'd0, 4'b0100, 32'd0);
        read(4'd0, v); check("R4 write zero", v[18], 1'b1);
        wr(4'd0, 4'b1011, 32'h0004_0000);
        read(4'd0, v); check("R4 lane off", v[18], 1'b1);

        // R3 clear while line high
        wr(4'd0, 4'b0100, 32'h0004_0000);
        read(4'd0, v); check("R3 cleared", v[18], 1'b0);
        repeat (5) tick();
        read(4'd0, v); check("R3 stays clear", v[18], 1'b0);
        dev_irq = 0; repeat (4) tick();
        dev_irq = 1; repeat (3) tick();
        read(4'd0, v); check("R3 rearmed", v[18], 1'b1);

        // R5 interrupt set wins
        wr(4'd0, 4'b0100, 32'h0004_0000);
        dev_irq = 0; repeat (4) tick();
        dev_irq = 1; tick(); tick();
        wr(4'd0, 4'b0100, 32'h0004_0000);
        read(4'd0, v); check("R5 irq set wins", v[18], 1'b1);

        // R6 and R5 error
        bus_abort = 1; tick(); bus_abort = 0;
        read(4'd0, v); check("R6 abort sets", v[17], 1'b1);
        bus_abort = 1;
        wr(4'd0, 4'b0100, 32'h0002_0000);
        bus_abort = 0;
        read(4'd0, v); check("R5 err set wins", v[17], 1'b1);
        wr(4'd0, 4'b0100, 32'h0002_0000);
        read(4'd0, v); check("R4 err cleared", v[17], 1'b0);

        // R7 / R8
        eot_done = 1; tick(); eot_done = 0;
        read(4'd0, v); check("R8 eot idle", v[16], 1'b0);
        wr(4'd0, 4'b0001, 32'h1);
        read(4'd0, v); check("R7 launch", {v[16], v[0]}, 2'b11);
        eot_done = 1; tick(); eot_done = 0;
        read(4'd0, v); check("R8 finish", {v[16], v[0]}, 2'b01);
        wr(4'd0, 4'b0001, 32'h1);
        eot_done = 1;
        wr(4'd0, 4'b0001, 32'h1);
        eot_done = 0;
        read(4'd0, v); check("R8 relaunch beats eot", v[16], 1'b1);

        // R9 read-only active, unimplemented bits
        dev_irq = 0;
        wr(4'd0, 4'b0100, 32'h0000_0000);
        read(4'd0, v); check("R9 active write ignored", v[16], 1'b1);
        wr(4'd0, 4'b1110, 32'hFFFF_FFFF);
        read(4'd0, v); check("R9 unimplemented read 0", v, 32'h0001_0001);
        wr(4'd0, 4'b0001, 32'h0);
        read(4'd0, v); check("R8 halt", {v[16], v[0]}, 2'b00);

        // R11 unmapped
        wr(4'd8, 4'hF, 32'hFFFF_FFFF);
        read(4'd8, v); check("R11 offset 8", v, 32'd0);
        wr(4'd2, 4'hF, 32'h0001_0001);
        read(4'd2, v); check("R11 misaligned", v, 32'd0);
        read(4'd0, v); check("R11 ctrl untouched", v, 32'd0);
        read(4'd4, v); check("R11 ptr untouched", v, 32'hDEAD_55EC);

        // Constrained random phase
        for (int i = 0; i < 3000; i++) begin
            automatic int pick = $urandom_range(0, 5);
            if ($urandom_range(0, 5) == 0) dev_irq = ~dev_irq;
            bus_abort  = ($urandom_range(0, 19) == 0);
            eot_done   = ($urandom_range(0, 9) == 0);
            host_wr    = ($urandom_range(0, 2) == 0);
            host_addr  = (pick < 3) ? 4'd0 : (pick == 3) ? 4'd4 : (pick == 4) ? 4'd12 : 4'd1;
            host_be    = 4'($urandom);
            host_wdata = $urandom;
            #1;
            v = exp_read(host_addr);
            if (host_addr == 4'd0) begin
                check("R7 start", {31'd0, host_rdata[0]}, {31'd0, v[0]});
                check("R8 active", {31'd0, host_rdata[16]}, {31'd0, v[16]});
                check("R6 error", {31'd0, host_rdata[17]}, {31'd0, v[17]});
                check("R2 interrupt", {31'd0, host_rdata[18]}, {31'd0, v[18]});
                check("R9 unimplemented", host_rdata & 32'hFFF8_FFFE, 32'd0);
            end else if (host_addr == 4'd4) begin
                if (m_ptr_known) check("R10 pointer", host_rdata, v);
            end else begin
                check("R11 unmapped", host_rdata, 32'd0);
            end
            tick();
        end
        host_wr = 0; bus_abort = 0; eot_done = 0;

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule